// File: doc/BRIEF.md
# Leaky Over-Current Event Counter

This block judges every low-side switching cycle of a half-bridge as either a fault cycle or a clean cycle. A cycle is a fault cycle when the digitised current-sense comparator flag is high while the low-side gate drive is on. Each fault cycle moves an up/down count one step up, and each clean cycle moves it one step down. The count never goes below zero. A short burst of noise therefore drains away over the following clean cycles. Sustained hard switching drives the count to the trip limit, and the block then raises a latched fault request.

The ballast sequencer enables counting in the modes that need over-current protection and removes the enable in the ignition phase. It can also clear the block directly. The comparator itself is outside the block: its result arrives as a flag synchronous to the clock. The count is exported so that it can be observed.

Top module: `oc_event_counter`

## Requirements
- R1: A cycle is evaluated when the low-side drive falls. Only one count step is taken per cycle. The new count appears on `count_o` on the second rising clock edge after the first edge that samples `lo_drive_i` low.
- R2: A cycle is a fault cycle when `sense_i` is sampled high on at least one clock edge where `lo_drive_i` is also high. A sense flag that is high only while the drive is low has no effect. The on-time record is cleared after each evaluation.
- R3: A fault cycle increments the count by exactly one.
- R4: A clean cycle decrements the count by one. A clean cycle at a count of zero leaves the count at zero.
- R5: A sense flag held high through the whole on-time gives a single increment.
- R6: `trip_o` rises on the same edge that the count reaches `TRIP_COUNT` (default 65). After that, the count and `trip_o` hold through any cycles until the block is cleared.
- R7: While `count_en_i` is low, the next clock edge clears the count to 0 and drops `trip_o`. Switching cycles are ignored for as long as the enable stays low.
- R8: A high `seq_clr_i` clears the count to 0 and drops `trip_o` on the next clock edge.
- R9: A low `rst_ni` clears the count and `trip_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seq_clr_i | input | 1 | Synchronous clear from the sequencer, active high |
| count_en_i | input | 1 | Counting enable (low during ignition) |
| lo_drive_i | input | 1 | Low-side gate drive, high means on |
| sense_i | input | 1 | Over-current comparator flag, synchronous |
| trip_o | output | 1 | Latched fault request |
| count_o | output | CNT_W (7) | Current event count |

## Verification
A count step has a latency of two clock edges. The first edge after the drive falls registers the verdict for the cycle. The second edge updates the counter. A clear from the enable or from `seq_clr_i` takes effect on the first edge, and a reset takes effect immediately. The bench changes inputs on falling clock edges. Each table vector is followed by a four-clock off-time before `count_o` is sampled, so every sample falls after the step is due. One directed test samples between the two edges to show that the count has not yet moved after the first edge and has moved after the second. Other directed tests sample the clears one edge after the request, and sample the reset in the middle of a clock period.

// File: rtl/oc_cnt_pkg.sv
package oc_cnt_pkg;
  typedef enum logic [1:0] {
    VERDICT_NONE  = 2'd0,
    VERDICT_CLEAN = 2'd1,
    VERDICT_FAULT = 2'd2
  } verdict_e;
endpackage

// File: rtl/oc_cycle_capture.sv
module oc_cycle_capture
  import oc_cnt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     enable_i,
  input  logic     lo_i,
  input  logic     sense_i,
  output verdict_e verdict_o
);
  logic     lo_q;
  logic     seen_q;
  verdict_e verdict_q;
  logic     fall;

  assign fall = lo_q & ~lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q      <= 1'b0;
      seen_q    <= 1'b0;
      verdict_q <= VERDICT_NONE;
    end else begin
      lo_q      <= lo_i;
      verdict_q <= VERDICT_NONE;
      if (!enable_i) begin
        seen_q <= 1'b0;
      end else if (fall) begin
        verdict_q <= seen_q ? VERDICT_FAULT : VERDICT_CLEAN;
        seen_q    <= 1'b0;
      end else if (lo_i && sense_i) begin
        seen_q <= 1'b1;
      end
    end
  end

  assign verdict_o = verdict_q;

  // verdict is a single-cycle strobe per falling edge
  assert_one_shot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_q != VERDICT_NONE) |=> (verdict_q == VERDICT_NONE));

  // sense during off-time leaves the record alone
  assert_off_time_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !lo_i && !lo_q) |=> (seen_q == $past(seen_q)));

  assert_gate_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (verdict_q == VERDICT_NONE));
endmodule

// File: rtl/oc_leaky_count.sv
module oc_leaky_count
  import oc_cnt_pkg::*;
#(
  parameter int TRIP_COUNT = 65,
  parameter int CNT_W      = $clog2(TRIP_COUNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  verdict_e         verdict_i,
  output logic [CNT_W-1:0] count_o,
  output logic             trip_o
);
  localparam logic [CNT_W-1:0] LIM  = CNT_W'(TRIP_COUNT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIP_COUNT - 1);

  logic [CNT_W-1:0] count_q;
  logic             trip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      trip_q  <= 1'b0;
    end else if (clr_i) begin
      count_q <= '0;
      trip_q  <= 1'b0;
    end else if (!trip_q) begin
      unique case (verdict_i)
        VERDICT_FAULT: begin
          count_q <= count_q + 1'b1;
          if (count_q == LAST) trip_q <= 1'b1;
        end
        VERDICT_CLEAN: if (count_q != '0) count_q <= count_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign count_o = count_q;
  assign trip_o  = trip_q;

  assert_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_i == VERDICT_FAULT && !clr_i && !trip_q) |=> (count_q == $past(count_q) + 1'b1));

  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_i == VERDICT_NONE && !clr_i) |=> $stable(count_q));

  assert_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_i == VERDICT_CLEAN && !clr_i && !trip_q && count_q != '0)
      |=> (count_q == $past(count_q) - 1'b1));

  assert_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_i == VERDICT_CLEAN && !clr_i && count_q == '0) |=> (count_q == '0));

  assert_trip_at_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_q) |-> (count_q == LIM));

  assert_trip_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_q && !clr_i) |=> (trip_q && count_q == LIM));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_q == '0 && !trip_q));
endmodule

// File: rtl/oc_event_counter.sv
module oc_event_counter
  import oc_cnt_pkg::*;
#(
  parameter int TRIP_COUNT = 65,
  parameter int CNT_W      = $clog2(TRIP_COUNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seq_clr_i,
  input  logic             count_en_i,
  input  logic             lo_drive_i,
  input  logic             sense_i,
  output logic             trip_o,
  output logic [CNT_W-1:0] count_o
);
  logic     clr;
  verdict_e verdict;

  assign clr = seq_clr_i | ~count_en_i;

  oc_cycle_capture u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (~clr),
    .lo_i     (lo_drive_i),
    .sense_i  (sense_i),
    .verdict_o(verdict)
  );

  oc_leaky_count #(
    .TRIP_COUNT(TRIP_COUNT),
    .CNT_W     (CNT_W)
  ) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .verdict_i(verdict),
    .count_o  (count_o),
    .trip_o   (trip_o)
  );

  assert_disable_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en_i |=> (count_o == '0 && !trip_o));
endmodule

// File: tb/oc_event_counter_tb.sv
module oc_event_counter_tb;
  localparam int TRIP = 65;
  localparam int W    = $clog2(TRIP + 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         seq_clr = 1'b0;
  logic         en = 1'b1;
  logic         lo = 1'b0;
  logic         sense = 1'b0;
  logic         trip;
  logic [W-1:0] cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  oc_event_counter #(.TRIP_COUNT(TRIP)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .seq_clr_i (seq_clr),
    .count_en_i(en),
    .lo_drive_i(lo),
    .sense_i   (sense),
    .trip_o    (trip),
    .count_o   (cnt)
  );

  // kind: 0 clean, 1 short sense pulse in on-time, 2 sense held all on-time,
  //       3 sense only during off-time
  // vector fields: [9:8] kind, [7:1] expected count, [0] expected trip
  localparam logic [9:0] VEC [12] = '{
    {2'd1, 7'd1, 1'b0}, {2'd2, 7'd2, 1'b0}, {2'd3, 7'd1, 1'b0},
    {2'd0, 7'd0, 1'b0}, {2'd0, 7'd0, 1'b0}, {2'd1, 7'd1, 1'b0},
    {2'd2, 7'd2, 1'b0}, {2'd0, 7'd1, 1'b0}, {2'd1, 7'd2, 1'b0},
    {2'd1, 7'd3, 1'b0}, {2'd0, 7'd2, 1'b0}, {2'd3, 7'd1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lo_cycle(input logic [1:0] kind);
    lo = 1'b1;
    for (int i = 0; i < 4; i++) begin
      sense = (kind == 2'd2) || (kind == 2'd1 && i == 1);
      @(negedge clk);
    end
    lo = 1'b0;
    for (int i = 0; i < 4; i++) begin
      sense = (kind == 2'd3);
      @(negedge clk);
    end
    sense = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset count", int'(cnt), 0);
    check("R9 reset trip", int'(trip), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: table walk
    foreach (VEC[i]) begin
      lo_cycle(VEC[i][9:8]);
      check($sformatf("R2/R3/R4/R5 vec%0d count", i), int'(cnt), int'(VEC[i][7:1]));
      check($sformatf("R6 vec%0d trip", i), int'(trip), int'(VEC[i][0]));
    end

    // R1: step lands on the second edge after the drive is sampled low
    lo = 1'b1; sense = 1'b1;
    @(negedge clk);
    sense = 1'b0;
    @(negedge clk);
    lo = 1'b0;
    @(negedge clk);
    check("R1 no step after first edge", int'(cnt), 1);
    @(negedge clk);
    check("R1 step after second edge", int'(cnt), 2);
    repeat (2) @(negedge clk);

    // R8: sequencer clear
    seq_clr = 1'b1;
    @(negedge clk);
    seq_clr = 1'b0;
    check("R8 clear count", int'(cnt), 0);

    // R6: trip at the limit
    for (int k = 0; k < TRIP - 1; k++) lo_cycle(2'd1);
    check("R6 count below limit", int'(cnt), TRIP - 1);
    check("R6 no trip below limit", int'(trip), 0);
    lo_cycle(2'd2);
    check("R6 count at limit", int'(cnt), TRIP);
    check("R6 trip at limit", int'(trip), 1);
    lo_cycle(2'd0);
    check("R6 hold count on clean", int'(cnt), TRIP);
    check("R6 hold trip on clean", int'(trip), 1);
    lo_cycle(2'd1);
    check("R6 hold count on fault", int'(cnt), TRIP);

    // R7: disable clears and ignores cycles
    en = 1'b0;
    @(negedge clk);
    check("R7 disable clears count", int'(cnt), 0);
    check("R7 disable clears trip", int'(trip), 0);
    lo_cycle(2'd2);
    lo_cycle(2'd1);
    check("R7 cycles ignored while disabled", int'(cnt), 0);
    en = 1'b1;
    @(negedge clk);
    lo_cycle(2'd1);
    check("R7 counts again after enable", int'(cnt), 1);

    // R9: asynchronous reset mid-period
    lo_cycle(2'd1);
    check("R9 pre-reset count", int'(cnt), 2);
    #2 rst_n = 1'b0;
    #1 check("R9 async count", int'(cnt), 0);
    check("R9 async trip", int'(trip), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule